// File: doc/BRIEF.md
# Prefetch Queue with Branch Folding

This block sits between an instruction fetcher and a dispatch stage. It requests instruction words from instruction memory ahead of need and keeps them, each tagged with its address, in a first-in first-out queue. The dispatch side takes words from the head of that queue. Because the two sides are decoupled, fetch goes on filling the queue while the downstream pipeline is stalled, and dispatch goes on draining it while instruction memory is slow to answer.

The fetch side looks at every returned word to see whether it is an unconditional jump. When it is, the block works out the jump destination at once and steers the next request there, so the word after the jump is never requested. If the queue already holds at least one other instruction when the jump arrives, the jump is dropped from the stream and never takes a dispatch slot. If the queue is empty at that moment, the jump word is queued and dispatched like any other word, so it costs one dispatch cycle.

Top module: `prefetch_fold_queue`

## Requirements
- R1: While reset is asserted and directly after it is released, `disp_valid` is 0, `imem_req` is 1 and `imem_addr` equals `RESET_PC`.
- R2: A request is accepted in a cycle where `imem_req` and `imem_ready` are both 1. For a word that is not a jump, the next request address is the accepted address plus 1. While `imem_ready` is 0, `imem_addr` does not change.
- R3: When one word is accepted and one word is dispatched in the same cycle, the occupancy of the queue does not change. A steady flow delivers one word per cycle.
- R4: While `disp_stall` is 1, nothing is dispatched and fetch goes on queuing words. Once `DEPTH` words are held, `imem_req` is 0.
- R5: While `imem_ready` is 0, dispatch goes on taking words from the queue until the queue is empty. Then `disp_valid` is 0.
- R6: A word is a jump when bits [15:12] are 4'hF. Its destination is its own address plus bits [7:0], sign-extended. The request after an accepted jump goes to that destination.
- R7: A jump that arrives while the queue holds at least one word is never presented on the dispatch side. The word dispatched after the older entries is the jump destination.
- R8: A jump that arrives while the queue is empty is queued. It is dispatched with its own address and word, and the destination word follows it.
- R9: Words are dispatched in the order they were accepted, and each carries its own address on `disp_pc`.
- R10: While `disp_valid` is 1 and `disp_ready` is 0, the head word and its address remain on the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| imem_req | output | 1 | Fetch request, raised whenever the queue has space |
| imem_addr | output | 16 | Address of the requested word |
| imem_ready | input | 1 | Instruction memory returns the requested word this cycle |
| imem_rdata | input | 16 | Returned instruction word |
| disp_valid | output | 1 | A queued word is offered to dispatch |
| disp_ready | input | 1 | Dispatch takes the offered word |
| disp_pc | output | 16 | Address of the offered word |
| disp_instr | output | 16 | Offered instruction word |
| disp_stall | input | 1 | Downstream hazard; blocks dispatch |

## Verification
A corrupted occupancy count or pointer shows up at once at the ports. It appears either as a skipped or repeated `disp_pc`, or as `imem_req` falling while there is still space, or staying high while the queue is full. The count change is one cycle after the disturbing push or pop. A wrong fold decision shows within one or two dispatches: the jump word appears on `disp_pc` when it should have vanished, or the destination word fails to follow the older entries. A wrong destination shows on `imem_addr` in the cycle right after the jump is accepted.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned AW    = 16;
  localparam int unsigned IW    = 16;
  localparam int unsigned OPC_W = 4;
  localparam int unsigned OFS_W = 8;
  localparam logic [OPC_W-1:0] JMP_OPC = '1;

  typedef struct packed {
    logic [AW-1:0] pc;
    logic [IW-1:0] word;
  } slot_t;

  function automatic logic is_jump(input logic [IW-1:0] w);
    return w[IW-1 -: OPC_W] == JMP_OPC;
  endfunction

  function automatic logic [AW-1:0] jump_dest(input logic [AW-1:0] pc,
                                              input logic [IW-1:0] w);
    return pc + {{(AW-OFS_W){w[OFS_W-1]}}, w[OFS_W-1:0]};
  endfunction
endpackage

// File: rtl/pfq_ring.sv
module pfq_ring
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  slot_t                        push_data,
  input  logic                         pop,
  output slot_t                        head,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  slot_t            store [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign cnt   = cnt_q;
  assign head  = store[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= push_data;
  end

  // R4: never written beyond capacity
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9: never read from an empty queue
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R3: simultaneous push and pop leave occupancy unchanged
  a_r3_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt_q));
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter logic [pfq_pkg::AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_full,
  input  logic          q_empty,
  input  logic          imem_ready,
  input  logic [IW-1:0] imem_rdata,
  output logic          imem_req,
  output logic [AW-1:0] imem_addr,
  output logic          push,
  output slot_t         push_data
);
  logic [AW-1:0] pc_q, pc_d;
  logic          take, jmp, fold;

  assign imem_req  = !q_full;
  assign imem_addr = pc_q;
  assign take      = imem_req && imem_ready;
  assign jmp       = is_jump(imem_rdata);
  assign fold      = take && jmp && !q_empty;
  assign push      = take && !fold;
  assign push_data = '{pc: pc_q, word: imem_rdata};

  always_comb begin
    pc_d = pc_q;
    if (take) pc_d = jmp ? jump_dest(pc_q, imem_rdata) : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  // R2: address held while memory has not answered
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req && !imem_ready) |=> $stable(imem_addr));
  // R2: plain words advance the address by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req && imem_ready && !is_jump(imem_rdata))
      |=> (imem_addr == $past(imem_addr) + 1'b1));
  // R7: a jump dropped from the stream never enters the queue
  a_r7_fold_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req && imem_ready && is_jump(imem_rdata) && !q_empty) |-> !push);
endmodule

// File: rtl/prefetch_fold_queue.sv
module prefetch_fold_queue
  import pfq_pkg::*;
#(
  parameter int unsigned   DEPTH    = 8,
  parameter logic [15:0]   RESET_PC = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          imem_req,
  output logic [AW-1:0] imem_addr,
  input  logic          imem_ready,
  input  logic [IW-1:0] imem_rdata,
  output logic          disp_valid,
  input  logic          disp_ready,
  output logic [AW-1:0] disp_pc,
  output logic [IW-1:0] disp_instr,
  input  logic          disp_stall
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  slot_t            wr_slot, hd_slot;
  logic             push, pop, full, empty;
  logic [CNT_W-1:0] level;

  pfq_fetch #(.RESET_PC(RESET_PC)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .q_full(full), .q_empty(empty),
    .imem_ready(imem_ready), .imem_rdata(imem_rdata),
    .imem_req(imem_req), .imem_addr(imem_addr),
    .push(push), .push_data(wr_slot)
  );

  pfq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(wr_slot), .pop(pop),
    .head(hd_slot), .cnt(level), .full(full), .empty(empty)
  );

  assign disp_valid = !empty && !disp_stall;
  assign pop        = disp_valid && disp_ready;
  assign disp_pc    = hd_slot.pc;
  assign disp_instr = hd_slot.word;

  // R4: no request while the queue is full
  a_r4_no_req_full: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CNT_W'(DEPTH)) |-> !imem_req);
  // R10: an offered word that is not taken stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> ($stable(disp_pc) && $stable(disp_instr)));
  // R6: request after an accepted jump goes to its destination
  a_r6_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req && imem_ready && is_jump(imem_rdata))
      |=> (imem_addr == $past(jump_dest(imem_addr, imem_rdata))));
endmodule

// File: tb/prefetch_fold_queue_bench.sv
module prefetch_fold_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        imem_req, imem_ready;
  logic [15:0] imem_addr, imem_rdata;
  logic        disp_valid, disp_ready, disp_stall;
  logic [15:0] disp_pc, disp_instr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [15:0] log_pc [512];
  logic [15:0] log_in [512];
  int          n_log = 0;

  always #10 clk = ~clk;

  prefetch_fold_queue u_prefetch_fold_queue (
    .clk(clk), .rst_n(rst_n),
    .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_ready(imem_ready), .imem_rdata(imem_rdata),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_pc(disp_pc), .disp_instr(disp_instr),
    .disp_stall(disp_stall)
  );

  // program: jump at 0x30 (+0x10 -> 0x40), jump at 0x48 (-0x10 -> 0x38)
  function automatic logic [15:0] prog(input logic [15:0] a);
    if (a == 16'h0030) return 16'hF010;
    if (a == 16'h0048) return 16'hF0F0;
    return {4'h1, a[11:0]};
  endfunction

  always_comb imem_rdata = prog(imem_addr);

  always @(negedge clk) begin
    if (rst_n && disp_valid && disp_ready && n_log < 512) begin
      log_pc[n_log] = disp_pc;
      log_in[n_log] = disp_instr;
      n_log = n_log + 1;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic        rdy;
    logic        stl;
    logic        drdy;
    logic [7:0]  n;
    logic        ev;
    logic [15:0] epc;
    logic        er;
    logic [15:0] ea;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 1'b0, 1'b1, 8'd5,  1'b1, 16'd4,  1'b1, 16'd5},
    '{1'b1, 1'b1, 1'b1, 8'd2,  1'b0, 16'd0,  1'b1, 16'd7},
    '{1'b1, 1'b1, 1'b1, 8'd10, 1'b0, 16'd0,  1'b0, 16'd12},
    '{1'b0, 1'b0, 1'b1, 8'd3,  1'b1, 16'd7,  1'b1, 16'd12},
    '{1'b1, 1'b0, 1'b1, 8'd4,  1'b1, 16'd11, 1'b1, 16'd16},
    '{1'b1, 1'b0, 1'b0, 8'd2,  1'b1, 16'd11, 1'b1, 16'd18},
    '{1'b0, 1'b0, 1'b1, 8'd7,  1'b0, 16'd0,  1'b1, 16'd18},
    '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 16'd18, 1'b1, 16'd19}
  };

  task automatic do_reset();
    rst_n      = 1'b0;
    imem_ready = 1'b0;
    disp_ready = 1'b0;
    disp_stall = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int base;
    int k;
    bit seen48;
    string tg;

    // R1: reset state
    rst_n      = 1'b0;
    imem_ready = 1'b0;
    disp_ready = 1'b0;
    disp_stall = 1'b0;
    #5;
    chk("R1 valid in reset", 32'(disp_valid), 32'd0);
    chk("R1 req in reset",   32'(imem_req),   32'd1);
    do_reset();
    chk("R1 valid after release", 32'(disp_valid), 32'd0);
    chk("R1 req after release",   32'(imem_req),   32'd1);
    chk("R1 addr after release",  32'(imem_addr),  32'h0);

    // table walk: sequential program, stalls and misses
    base = n_log;
    for (int i = 0; i < 8; i++) begin
      imem_ready = TBL[i].rdy;
      disp_stall = TBL[i].stl;
      disp_ready = TBL[i].drdy;
      for (int c = 0; c < int'(TBL[i].n); c++) tick();
      case (i)
        1, 2:    tg = "R4";
        3, 6:    tg = "R5";
        5:       tg = "R10";
        default: tg = "R3";
      endcase
      chk({tg, " valid"}, 32'(disp_valid), 32'(TBL[i].ev));
      if (TBL[i].ev) begin
        chk({tg, " pc"},    32'(disp_pc),    32'(TBL[i].epc));
        chk({tg, " instr"}, 32'(disp_instr), 32'({4'h1, TBL[i].epc[11:0]}));
      end
      chk("R4 req", 32'(imem_req),  32'(TBL[i].er));
      chk("R2 addr", 32'(imem_addr), 32'(TBL[i].ea));
    end
    chk("R3 dispatched count", 32'(n_log - base), 32'd18);
    k = 0;
    for (int j = 0; j < 18; j++)
      if (log_pc[base + j] !== 16'(j) || log_in[base + j] !== {4'h1, 12'(j)}) k++;
    chk("R9 order and tags", 32'(k), 32'd0);

    // jump handling: empty-queue jump then folded jump
    do_reset();
    base = n_log;
    imem_ready = 1'b1;
    disp_ready = 1'b1;
    for (int c = 0; c < 200 && imem_addr != 16'h0030; c++) tick();
    chk("R2 reached 0x30", 32'(imem_addr), 32'h30);
    imem_ready = 1'b0;
    for (int c = 0; c < 20 && disp_valid; c++) tick();
    chk("R5 drained", 32'(disp_valid), 32'd0);
    imem_ready = 1'b1;
    tick();
    chk("R6 forward dest", 32'(imem_addr), 32'h40);
    chk("R8 jump offered valid", 32'(disp_valid), 32'd1);
    chk("R8 jump offered pc", 32'(disp_pc), 32'h30);
    chk("R8 jump offered word", 32'(disp_instr), 32'hF010);
    repeat (30) tick();

    k = -1;
    for (int j = base; j < n_log; j++)
      if (k < 0 && log_pc[j] == 16'h0030) k = j;
    chk("R8 jump dispatched", 32'(k >= 0), 32'd1);
    if (k >= 0) begin
      for (int j = 0; j < 8; j++)
        chk("R6 dest run", 32'(log_pc[k + 1 + j]), 32'(16'h40 + 16'(j)));
      chk("R7 after fold", 32'(log_pc[k + 9]), 32'h38);
      chk("R6 backward dest word", 32'(log_in[k + 9]), 32'h1038);
    end
    seen48 = 0;
    for (int j = base; j < n_log; j++)
      if (log_pc[j] == 16'h0048) seen48 = 1;
    chk("R7 folded jump never offered", 32'(seen48), 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule